// File: doc/BRIEF.md
# Mode-0 Parallel I/O Port Controller with Edge Interrupt

This block drives and samples 24 general-purpose digital lines. The lines form three byte-wide ports, A, B and C. Port C splits into a lower and an upper nibble, and each nibble has its own direction. A host reaches the block through a small synchronous register bus with byte-wide data. Through that bus it sets which groups drive their pins, loads the output latches, and reads the ports. A port bit set as output reads back its latch. A port bit set as input reads back its synchronized pin.

Two port C pins can raise an interrupt: line 0 of port C and line 4 of port C. A 2-bit mode field in the interrupt control register selects which of them count. A rising edge on a selected pin sets a sticky pending flag. The host clears that flag by writing a one to it. The interrupt output is high while any selected pending flag is set.

The block has two resets:

- A cold reset returns everything to its idle state.
- A warm reset leaves the pin directions and output latches as they were. It clears only the interrupt state and the input sampling.

Top module: `pio24_ctrl`

## Requirements
- R1: A cold reset sets every group to input (`pin_oe` all 0), clears all output latches (`pin_out` all 0), clears the mode field and both pending flags, and holds `irq` low.
- R2: A write to offset 0, 1 or 2 loads the latch of port A, B or C. The new value appears on the matching byte of `pin_out` (A in bits 7:0, B in 15:8, C in 23:16) after the write cycle.
- R3: The direction register at offset 3 works as follows:
  - Bit 0 controls port A, bit 1 controls port B, bit 2 controls C bits 3:0, and bit 3 controls C bits 7:4.
  - A 1 makes that group an output and drives its `pin_oe` bits high.
  - A read returns the four bits in bits 3:0, with bits 7:4 reading 0.
- R4: A read of offsets 0 to 2 returns, bit by bit, the latch for output bits and the pin level for input bits. The pin level passes through a two-flop synchronizer, so it is visible two clock edges after it settles.
- R5: The interrupt control register is at offset 32. Its fields are:
  - bits 1:0: the mode field.
  - bit 2: reads the PC0 pending flag.
  - bit 3: reads the PC4 pending flag.
  - bits 7:4: read 0.
- R6: In mode 01, a rising edge on pin PC0 (`pin_in[16]`) sets the PC0 flag. Edges on PC4 (`pin_in[20]`) set nothing.
- R7: In mode 10, rising edges on PC0 and on PC4 each set their own pending flag.
- R8: In modes 00 and 11, no pin edge sets a pending flag, and `irq` stays low.
- R9: `irq` is the OR of the pending flags that the current mode enables. A flag stays set after its pin falls. A flag held from an earlier mode does not raise `irq` unless the current mode enables it.
- R10: Writing offset 32 with bit 2 or bit 3 at 1 clears the PC0 or PC4 flag. A 0 in that bit leaves the flag unchanged.
- R11: A warm reset leaves the direction settings and output latches unchanged on `pin_oe` and `pin_out`, and ignores bus writes made during it. It clears the mode field, the pending flags and the synchronizer.
- R12: Reads of any offset other than 0, 1, 2, 3 and 32 return 0. Writes to those offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst | input | 1 | Synchronous active-high power-on reset, clears all state |
| warm_rst | input | 1 | Synchronous active-high warm reset, keeps directions and latches |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pin_in | input | 24 | Pin levels, port A in 7:0, B in 15:8, C in 23:16 |
| pin_out | output | 24 | Output latch values, same layout |
| pin_oe | output | 24 | Per-line output enable, 1 drives the pin |
| irq | output | 1 | Interrupt request, level |

## Verification
Some behaviours hold on every cycle, so the bound assertions check them continuously:

- the outputs are clear after a cold reset;
- a direction write lands on `pin_oe` on the next cycle;
- a warm reset holds `pin_oe` and `pin_out` steady;
- `irq` is high only when the mode enables a set flag;
- a PC4 flag rises only in mode 10, and the PC0 flag only in mode 01 or 10;
- a pending flag stays set until a write clears it.

The bench's scenarios cover what the assertions cannot: the per-bit mix of latch and pin values in port reads, the two-edge synchronizer latency, the clear-by-one encoding and the zero reads from undefined offsets.

// File: rtl/pio24_pkg.sv
package pio24_pkg;

    localparam int PORT_W    = 8;
    localparam int NUM_PORTS = 3;
    localparam int LINES     = PORT_W * NUM_PORTS;
    localparam int NIB       = PORT_W / 2;
    localparam int GROUPS    = NUM_PORTS + 1;
    localparam int ADDR_W    = 6;
    localparam int SYNC_DEPTH = 2;

    localparam int PC0_BIT = 2 * PORT_W;
    localparam int PC4_BIT = 2 * PORT_W + NIB;

    localparam logic [ADDR_W-1:0] OFF_DIR = ADDR_W'(3);
    localparam logic [ADDR_W-1:0] OFF_ICR = ADDR_W'(32);

    typedef enum logic [1:0] {
        IM_OFF_A = 2'b00,
        IM_PC0   = 2'b01,
        IM_BOTH  = 2'b10,
        IM_OFF_B = 2'b11
    } irq_mode_e;

    typedef struct packed {
        logic [3:0] rsvd;
        logic       pend_hi;
        logic       pend_lo;
        irq_mode_e  mode;
    } icr_t;

    // group index of a line: A=0, B=1, C low nibble=2, C high nibble=3
    function automatic logic [LINES-1:0] expand_dir(input logic [GROUPS-1:0] d);
        logic [LINES-1:0] r;
        for (int i = 0; i < LINES; i++) begin
            int port;
            int grp;
            port = i / PORT_W;
            if (port < NUM_PORTS - 1) grp = port;
            else grp = (NUM_PORTS - 1) + (((i % PORT_W) >= NIB) ? 1 : 0);
            r[i] = d[grp];
        end
        return r;
    endfunction

    // bit 0 enables PC0, bit 1 enables PC4
    function automatic logic [1:0] src_enable(input irq_mode_e m);
        case (m)
            IM_PC0:  return 2'b01;
            IM_BOTH: return 2'b11;
            default: return 2'b00;
        endcase
    endfunction

endpackage

// File: rtl/pio24_sync.sv
module pio24_sync #(
    parameter int W      = 24,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         clr,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] st;

    always_ff @(posedge clk) begin
        if (clr) st <= '0;
        else begin
            st[0] <= d;
            for (int s = 1; s < STAGES; s++) st[s] <= st[s-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/pio24_port_regs.sv
module pio24_port_regs
    import pio24_pkg::*;
(
    input  logic                 clk,
    input  logic                 cold_rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [PORT_W-1:0]    wdata,
    output logic [GROUPS-1:0]    dir_q,
    output logic [LINES-1:0]     latch_q
);
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        always_ff @(posedge clk) begin
            if (cold_rst) latch_q[p*PORT_W +: PORT_W] <= '0;
            else if (wr_en && addr == ADDR_W'(p))
                latch_q[p*PORT_W +: PORT_W] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (cold_rst) dir_q <= '0;
        else if (wr_en && addr == OFF_DIR) dir_q <= wdata[GROUPS-1:0];
    end
endmodule

// File: rtl/pio24_irq.sv
module pio24_irq
    import pio24_pkg::*;
(
    input  logic              clk,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        wdata,
    input  logic [1:0]        src,
    output irq_mode_e         mode_q,
    output logic [1:0]        pend_q,
    output logic              irq
);
    logic [1:0] prev_q;
    logic [1:0] rise;
    logic [1:0] en;
    logic       wr_icr;

    assign rise   = src & ~prev_q;
    assign en     = src_enable(mode_q);
    assign wr_icr = wr_en && (addr == OFF_ICR);

    always_ff @(posedge clk) begin
        if (clr) begin
            mode_q <= IM_OFF_A;
            pend_q <= '0;
            prev_q <= '0;
        end else begin
            prev_q <= src;
            if (wr_icr) mode_q <= irq_mode_e'(wdata[1:0]);
            for (int k = 0; k < 2; k++)
                pend_q[k] <= (rise[k] & en[k]) | (pend_q[k] & ~(wr_icr & wdata[2+k]));
        end
    end

    assign irq = |(pend_q & en);
endmodule

// File: rtl/pio24_ctrl.sv
module pio24_ctrl
    import pio24_pkg::*;
(
    input  logic              clk,
    input  logic              cold_rst,
    input  logic              warm_rst,
    input  logic              bus_wr,
    input  logic [5:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [23:0]       pin_in,
    output logic [23:0]       pin_out,
    output logic [23:0]       pin_oe,
    output logic              irq
);
    logic              wr_ok;
    logic              soft_clr;
    logic [GROUPS-1:0] dir_w;
    logic [LINES-1:0]  latch_w;
    logic [LINES-1:0]  pin_s;
    logic [LINES-1:0]  view;
    irq_mode_e         mode_w;
    logic [1:0]        pend_w;
    icr_t              icr;

    assign wr_ok    = bus_wr & ~warm_rst & ~cold_rst;
    assign soft_clr = cold_rst | warm_rst;

    pio24_sync #(.W(LINES), .STAGES(SYNC_DEPTH)) u_sync (
        .clk (clk),
        .clr (soft_clr),
        .d   (pin_in),
        .q   (pin_s)
    );

    pio24_port_regs u_regs (
        .clk      (clk),
        .cold_rst (cold_rst),
        .wr_en    (wr_ok),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .dir_q    (dir_w),
        .latch_q  (latch_w)
    );

    pio24_irq u_irq (
        .clk    (clk),
        .clr    (soft_clr),
        .wr_en  (wr_ok),
        .addr   (bus_addr),
        .wdata  (bus_wdata[3:0]),
        .src    ({pin_s[PC4_BIT], pin_s[PC0_BIT]}),
        .mode_q (mode_w),
        .pend_q (pend_w),
        .irq    (irq)
    );

    assign pin_oe  = expand_dir(dir_w);
    assign pin_out = latch_w;
    assign view    = (latch_w & pin_oe) | (pin_s & ~pin_oe);

    always_comb begin
        icr.rsvd    = '0;
        icr.pend_hi = pend_w[1];
        icr.pend_lo = pend_w[0];
        icr.mode    = mode_w;
        bus_rdata   = '0;
        for (int p = 0; p < NUM_PORTS; p++)
            if (bus_addr == ADDR_W'(p)) bus_rdata = view[p*PORT_W +: PORT_W];
        if (bus_addr == OFF_DIR) bus_rdata = PORT_W'(dir_w);
        if (bus_addr == OFF_ICR) bus_rdata = icr;
    end
endmodule

// File: rtl/pio24_ctrl_chk.sv
module pio24_ctrl_chk (
    input logic        clk,
    input logic        cold_rst,
    input logic        warm_rst,
    input logic        bus_wr,
    input logic [5:0]  bus_addr,
    input logic [3:0]  bus_wdata,
    input logic [23:0] pin_out,
    input logic [23:0] pin_oe,
    input logic        irq,
    input logic [1:0]  mode,
    input logic [1:0]  pend
);
    logic cold_q = 1'b0;
    always_ff @(posedge clk) cold_q <= cold_rst;

    // R1
    p_cold_clears_r1: assert property (@(posedge clk) disable iff (cold_rst)
        cold_q |-> (pin_oe == '0 && pin_out == '0 && !irq));

    // R3
    p_dir_write_r3: assert property (@(posedge clk) disable iff (cold_rst || warm_rst)
        (bus_wr && bus_addr == 6'd3) |=>
        (pin_oe[0] == $past(bus_wdata[0]) && pin_oe[8] == $past(bus_wdata[1]) &&
         pin_oe[16] == $past(bus_wdata[2]) && pin_oe[20] == $past(bus_wdata[3])));

    // R11
    p_warm_keeps_r11: assert property (@(posedge clk) disable iff (cold_rst)
        warm_rst |=> ($stable(pin_out) && $stable(pin_oe)));

    // R9
    p_irq_source_r9: assert property (@(posedge clk) disable iff (cold_rst || warm_rst)
        irq |-> ((mode == 2'b01 && pend[0]) || (mode == 2'b10 && pend != 2'b00)));

    // R6, R7
    p_pc4_only_mode10_r6: assert property (@(posedge clk) disable iff (cold_rst || warm_rst)
        $rose(pend[1]) |-> $past(mode) == 2'b10);

    // R8
    p_pc0_mode_gate_r8: assert property (@(posedge clk) disable iff (cold_rst || warm_rst)
        $rose(pend[0]) |-> ($past(mode) == 2'b01 || $past(mode) == 2'b10));

    // R10
    p_pend_sticky_r10: assert property (@(posedge clk) disable iff (cold_rst || warm_rst)
        (pend[0] && !(bus_wr && bus_addr == 6'd32 && bus_wdata[2])) |=> pend[0]);
endmodule

bind pio24_ctrl pio24_ctrl_chk u_chk (
    .clk       (clk),
    .cold_rst  (cold_rst),
    .warm_rst  (warm_rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata[3:0]),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .mode      (mode_w),
    .pend      (pend_w)
);

// File: tb/pio24_ctrl_test.sv
module pio24_ctrl_test;
    logic        clk = 1'b0;
    logic        cold_rst = 1'b1;
    logic        warm_rst = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [23:0] pin_in = '0;
    logic [23:0] pin_out;
    logic [23:0] pin_oe;
    logic        irq;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pio24_ctrl uut (
        .clk(clk), .cold_rst(cold_rst), .warm_rst(warm_rst), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic do_cold();
        @(negedge clk); cold_rst = 1'b1;
        @(negedge clk); cold_rst = 1'b0;
    endtask

    task automatic t_cold();
        logic [7:0] d;
        do_cold();
        chk("R1 pin_oe", int'(pin_oe), 0);
        chk("R1 pin_out", int'(pin_out), 0);
        chk("R1 irq", int'(irq), 0);
        rd(6'd32, d); chk("R1 icr", int'(d), 0);
        rd(6'd3, d);  chk("R1 dir", int'(d), 0);
    endtask

    task automatic t_ports();
        logic [7:0] d;
        wr(6'd3, 8'h0F);
        wr(6'd0, 8'hA5); wr(6'd1, 8'h3C); wr(6'd2, 8'h96);
        chk("R2 pin_out", int'(pin_out), 24'h963CA5);
        chk("R3 all out", int'(pin_oe), 24'hFFFFFF);
        rd(6'd3, d); chk("R3 dir read", int'(d), 8'h0F);
        rd(6'd0, d); chk("R4 A latch read", int'(d), 8'hA5);
        wr(6'd3, 8'h05);
        chk("R3 mixed oe", int'(pin_oe), 24'h0F00FF);
        pin_in = 24'h5AE711;
        settle();
        rd(6'd1, d); chk("R4 B pin read", int'(d), 8'hE7);
        rd(6'd2, d); chk("R4 C mixed read", int'(d), 8'h56);
        rd(6'd0, d); chk("R4 A out ignores pin", int'(d), 8'hA5);
        pin_in = '0;
        wr(6'd3, 8'h00);
        settle();
    endtask

    task automatic t_mode01();
        logic [7:0] d;
        wr(6'd32, 8'h01);
        pin_in[20] = 1'b1; settle();
        chk("R6 PC4 ignored irq", int'(irq), 0);
        rd(6'd32, d); chk("R6 PC4 ignored icr", int'(d), 8'h01);
        pin_in[20] = 1'b0;
        pin_in[16] = 1'b1; settle();
        chk("R6 PC0 irq", int'(irq), 1);
        rd(6'd32, d); chk("R5 icr pend0", int'(d), 8'h05);
        pin_in[16] = 1'b0; settle();
        chk("R9 sticky", int'(irq), 1);
        wr(6'd32, 8'h05);
        chk("R10 clear irq", int'(irq), 0);
        rd(6'd32, d); chk("R10 clear icr", int'(d), 8'h01);
    endtask

    task automatic t_mode10();
        logic [7:0] d;
        wr(6'd32, 8'h02);
        pin_in[20] = 1'b1; settle();
        chk("R7 PC4 irq", int'(irq), 1);
        rd(6'd32, d); chk("R7 PC4 icr", int'(d), 8'h0A);
        pin_in[20] = 1'b0;
        pin_in[16] = 1'b1; settle();
        rd(6'd32, d); chk("R7 both pend", int'(d), 8'h0E);
        pin_in[16] = 1'b0; settle();
        wr(6'd32, 8'h06);
        rd(6'd32, d); chk("R10 zero keeps", int'(d), 8'h0A);
        wr(6'd32, 8'h01);
        chk("R9 masked flag", int'(irq), 0);
        rd(6'd32, d); chk("R9 held flag", int'(d), 8'h09);
        wr(6'd32, 8'h08);
        rd(6'd32, d); chk("R10 clear hi", int'(d), 8'h00);
    endtask

    task automatic t_off();
        logic [7:0] d;
        pin_in[16] = 1'b1; pin_in[20] = 1'b1; settle();
        chk("R8 mode00 irq", int'(irq), 0);
        rd(6'd32, d); chk("R8 mode00 icr", int'(d), 8'h00);
        pin_in[16] = 1'b0; pin_in[20] = 1'b0; settle();
        wr(6'd32, 8'h03);
        pin_in[16] = 1'b1; pin_in[20] = 1'b1; settle();
        chk("R8 mode11 irq", int'(irq), 0);
        rd(6'd32, d); chk("R8 mode11 icr", int'(d), 8'h03);
        pin_in[16] = 1'b0; pin_in[20] = 1'b0;
        wr(6'd32, 8'h00);
        settle();
    endtask

    task automatic t_warm();
        logic [7:0] d;
        wr(6'd3, 8'h0B);
        wr(6'd0, 8'h12); wr(6'd1, 8'h34); wr(6'd2, 8'h56);
        wr(6'd32, 8'h02);
        pin_in[20] = 1'b1; settle();
        chk("R11 pre irq", int'(irq), 1);
        @(negedge clk);
        warm_rst = 1'b1; bus_wr = 1'b1; bus_addr = 6'd0; bus_wdata = 8'hFF;
        @(negedge clk);
        warm_rst = 1'b0; bus_wr = 1'b0;
        chk("R11 pin_out kept", int'(pin_out), 24'h563412);
        chk("R11 pin_oe kept", int'(pin_oe), 24'hF0FFFF);
        chk("R11 irq cleared", int'(irq), 0);
        rd(6'd32, d); chk("R11 icr cleared", int'(d), 8'h00);
        rd(6'd3, d); chk("R11 dir kept", int'(d), 8'h0B);
        pin_in = '0;
        do_cold();
        chk("R1 cold after warm oe", int'(pin_oe), 0);
        chk("R1 cold after warm out", int'(pin_out), 0);
    endtask

    task automatic t_undef();
        logic [7:0] d;
        wr(6'd3, 8'h01); wr(6'd0, 8'hC3);
        wr(6'd5, 8'hFF); wr(6'd33, 8'hFF); wr(6'd63, 8'hFF);
        rd(6'd5, d);  chk("R12 read 5", int'(d), 0);
        rd(6'd33, d); chk("R12 read 33", int'(d), 0);
        rd(6'd63, d); chk("R12 read 63", int'(d), 0);
        rd(6'd3, d);  chk("R12 dir unchanged", int'(d), 8'h01);
        rd(6'd32, d); chk("R12 icr unchanged", int'(d), 8'h00);
        chk("R12 pin_out unchanged", int'(pin_out), 24'h0000C3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_cold();
        t_ports();
        t_mode01();
        t_mode10();
        t_off();
        t_warm();
        t_undef();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule